// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in-first-out store built from registers. It holds 64 words, has a 6-bit stack pointer and a single data register. All transfers into and out of the stack pass through that data register. A push copies the data register onto the stack. A pop moves the top word back into the data register. The data register can also be loaded from an external input while no stack operation is requested.

The pointer is pre-incremented on a push and post-decremented on a pop. After reset the pointer is 0, so the first push fills location 1. The stack becomes full when the pointer wraps back to 0, which makes location 0 the last slot filled.

Occupancy is tracked by a three-state machine: `ST_EMPTY`, `ST_PART` and `ST_FULL`. The FULL and EMPTY flags are decoded from this state. The machine has the following transitions:
- push from `ST_EMPTY`, or from `ST_PART`, moves to `ST_PART`, or to `ST_FULL` if the incremented pointer is 0;
- pop from `ST_PART` moves to `ST_EMPTY` if the decremented pointer is 0;
- pop from `ST_FULL` moves to `ST_PART`, or to `ST_EMPTY` if the decremented pointer is 0.

An operation that would overflow or underflow is refused and reported with a one-cycle error pulse.

Top module: `lifo_regstack`

## Requirements
- R1: After reset the pointer is 0, EMPTY is 1, FULL is 0, the error output is 0 and the data register is 0.
- R2: A push (push high, pop low, not full) increments the pointer, writes the data register into the entry at the new pointer value, and clears EMPTY.
- R3: When the pointer is 0 after a push, FULL is set. This happens on the 64th push after reset. The word from that push sits in location 0 and is the first word returned by the next pop.
- R4: A pop (pop high, push low, not empty) loads the entry at the current pointer into the data register, decrements the pointer and clears FULL.
- R5: When the pointer is 0 after a pop, EMPTY is set.
- R6: Pops return words in the reverse order of the pushes that stored them.
- R7: A push while FULL is 1 changes neither the pointer, nor the flags, nor the data register, and drives the error output high for exactly the following cycle.
- R8: A pop while EMPTY is 1 changes neither the pointer, nor the flags, nor the data register, and drives the error output high for exactly the following cycle.
- R9: When push and pop are both high in a cycle, no operation is performed. Pointer, flags and data register are unchanged, no error pulse is raised, and a load requested in that cycle is not performed.
- R10: Load high with push and pop both low copies the data input into the data register on the next clock edge. Load high together with a push is ignored, and the push stores the old data register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| ld_i | input | 1 | Load data register from `din_i` |
| din_i | input | DATA_W | External data for loads |
| dr_o | output | DATA_W | Data register contents |
| sp_o | output | PTR_W | Stack pointer |
| full_o | output | 1 | FULL flag |
| empty_o | output | 1 | EMPTY flag |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
The hardest condition to reach from the ports is the wrap of the pointer to 0 on the 64th push, and the refused push that follows it. Reaching it takes a full fill, with a distinct word loaded before every push. The bench therefore runs a directed fill of 64 load-then-push pairs and checks the pointer and flags at the 63rd and 64th pushes. It then pushes once more into the full stack and drains all 64 entries, comparing each popped word against the fill order reversed. The short vector table before the fill covers the mixed cases: underflow, simultaneous push and pop, and a load colliding with a push.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } lrs_state_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } lrs_op_t;

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
    import lrs_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             ld_i,
    output lrs_op_t          op_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [PTR_W-1:0] rd_addr_o,
    output logic [PTR_W-1:0] sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    lrs_state_t       state_q, state_d;
    logic [PTR_W-1:0] sp_q, sp_d;
    logic [PTR_W-1:0] sp_inc, sp_dec;
    logic             want_push, want_pop, refuse;
    lrs_op_t          op;
    logic             err_q;

    assign sp_inc = sp_q + 1'b1;
    assign sp_dec = sp_q - 1'b1;

    // request arbitration: simultaneous push and pop cancel each other
    always_comb begin
        want_push = push_i & ~pop_i;
        want_pop  = pop_i & ~push_i;
        refuse    = (want_push && state_q == ST_FULL) ||
                    (want_pop  && state_q == ST_EMPTY);
        op        = OP_IDLE;
        if (want_push && state_q != ST_FULL)
            op = OP_PUSH;
        else if (want_pop && state_q != ST_EMPTY)
            op = OP_POP;
        else if (ld_i && !push_i && !pop_i)
            op = OP_LOAD;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_PUSH)
                    state_d = (sp_inc == '0) ? ST_FULL : ST_PART;
            end
            ST_PART: begin
                if (op == OP_PUSH && sp_inc == '0)
                    state_d = ST_FULL;
                else if (op == OP_POP && sp_dec == '0)
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (op == OP_POP)
                    state_d = (sp_dec == '0) ? ST_EMPTY : ST_PART;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // pointer
    always_comb begin
        sp_d = sp_q;
        unique case (op)
            OP_PUSH: sp_d = sp_inc;
            OP_POP:  sp_d = sp_dec;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q  <= '0;
            err_q <= 1'b0;
        end else begin
            sp_q  <= sp_d;
            err_q <= refuse;
        end
    end

    // outputs decoded from state
    always_comb begin
        full_o    = (state_q == ST_FULL);
        empty_o   = (state_q == ST_EMPTY);
        op_o      = op;
        wr_addr_o = sp_inc;
        rd_addr_o = sp_q;
        sp_o      = sp_q;
        err_o     = err_q;
    end

    // R2
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)) && !empty_o);

    // R4
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (sp_o == PTR_W'($past(sp_o) - 1'b1)) && !full_o);

    // R3
    full_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (sp_o == '0));

    // R5
    empty_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (sp_o == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> err_o && empty_o && $stable(sp_o));

    // R9
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && !err_o);

    // R1
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: rtl/lrs_store.sv
module lrs_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_addr_i == PTR_W'(g))
                cells[g] <= wr_data_i;
        end
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/lrs_dreg.sv
module lrs_dreg
    import lrs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lrs_op_t           op_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dr_o
);

    logic [DATA_W-1:0] dr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dr_q <= '0;
        else begin
            unique case (op_i)
                OP_POP:  dr_q <= rd_data_i;
                OP_LOAD: dr_q <= din_i;
                default: dr_q <= dr_q;
            endcase
        end
    end

    assign dr_o = dr_q;

    // R10
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> dr_o == $past(din_i));

    // R4
    pop_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP) |=> dr_o == $past(rd_data_i));

    // R2
    push_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH) |=> $stable(dr_o));

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
    import lrs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dr_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    lrs_op_t           op;
    logic [PTR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] dr;

    lrs_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .ld_i      (ld_i),
        .op_o      (op),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .sp_o      (sp_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    lrs_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .wr_en_i   (op == OP_PUSH),
        .wr_addr_i (wr_addr),
        .wr_data_i (dr),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    lrs_dreg #(.DATA_W(DATA_W)) u_dreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .rd_data_i (rd_data),
        .din_i     (din_i),
        .dr_o      (dr)
    );

    assign dr_o = dr;

endmodule

// File: tb/tb_lifo_regstack.sv
module tb_lifo_regstack;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 6;
    localparam int DEPTH  = 1 << PTR_W;
    localparam int NVEC   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0, pop_i = 1'b0, ld_i = 1'b0;
    logic [DATA_W-1:0] din_i = '0;
    logic [DATA_W-1:0] dr_o;
    logic [PTR_W-1:0]  sp_o;
    logic              full_o, empty_o, err_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    lifo_regstack #(.DATA_W(DATA_W), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .ld_i(ld_i),
        .din_i(din_i), .dr_o(dr_o), .sp_o(sp_o), .full_o(full_o),
        .empty_o(empty_o), .err_o(err_o)
    );

    // fields: push pop ld din[8] | dr[8] sp[6] full empty err
    localparam logic [27:0] VECS [0:NVEC-1] = '{
        {1'b0,1'b1,1'b0,8'h00, 8'h00,6'd0,1'b0,1'b1,1'b1},  // R8 pop on empty
        {1'b0,1'b0,1'b1,8'hA5, 8'hA5,6'd0,1'b0,1'b1,1'b0},  // R10 load
        {1'b1,1'b0,1'b0,8'h00, 8'hA5,6'd1,1'b0,1'b0,1'b0},  // R2 push
        {1'b0,1'b0,1'b1,8'h3C, 8'h3C,6'd1,1'b0,1'b0,1'b0},  // R10 load
        {1'b1,1'b0,1'b1,8'h77, 8'h3C,6'd2,1'b0,1'b0,1'b0},  // R10 load with push ignored
        {1'b1,1'b1,1'b1,8'h11, 8'h3C,6'd2,1'b0,1'b0,1'b0},  // R9 both requests
        {1'b0,1'b0,1'b1,8'h00, 8'h00,6'd2,1'b0,1'b0,1'b0},  // R10 load zero
        {1'b0,1'b1,1'b0,8'h00, 8'h3C,6'd1,1'b0,1'b0,1'b0},  // R4 pop
        {1'b0,1'b1,1'b0,8'h00, 8'hA5,6'd0,1'b0,1'b1,1'b0},  // R5 pop to empty
        {1'b0,1'b1,1'b0,8'h00, 8'hA5,6'd0,1'b0,1'b1,1'b1},  // R8 underflow
        {1'b0,1'b0,1'b0,8'h00, 8'hA5,6'd0,1'b0,1'b1,1'b0}   // R8 pulse ends
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic p, input logic q, input logic l, input logic [DATA_W-1:0] d);
        push_i = p; pop_i = q; ld_i = l; din_i = d;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; ld_i = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] fill_val(input int i);
        return DATA_W'(i * 7 + 3);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dr", 32'(dr_o), 0);
        chk("R1 sp", 32'(sp_o), 0);
        chk("R1 full", 32'(full_o), 0);
        chk("R1 empty", 32'(empty_o), 1);
        chk("R1 err", 32'(err_o), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [27:0] e;
            e = VECS[v];
            cyc(e[27], e[26], e[25], e[24:17]);
            chk("R2/R4/R8/R9/R10 vec dr", 32'(dr_o), 32'(e[16:9]));
            chk("R2/R4/R5 vec sp", 32'(sp_o), 32'(e[8:3]));
            chk("R3/R4 vec full", 32'(full_o), 32'(e[2]));
            chk("R2/R5 vec empty", 32'(empty_o), 32'(e[1]));
            chk("R7/R8/R9 vec err", 32'(err_o), 32'(e[0]));
        end

        // directed fill to full
        for (int i = 1; i <= DEPTH; i++) begin
            cyc(1'b0, 1'b0, 1'b1, fill_val(i));
            cyc(1'b1, 1'b0, 1'b0, '0);
            if (i == DEPTH - 1) begin
                chk("R2 sp at 63", 32'(sp_o), 63);
                chk("R3 not full at 63", 32'(full_o), 0);
            end
        end
        chk("R3 sp wraps", 32'(sp_o), 0);
        chk("R3 full set", 32'(full_o), 1);
        chk("R2 empty clear", 32'(empty_o), 0);

        // R7 overflow refused
        cyc(1'b0, 1'b0, 1'b1, 8'hEE);
        cyc(1'b1, 1'b0, 1'b0, '0);
        chk("R7 err", 32'(err_o), 1);
        chk("R7 sp", 32'(sp_o), 0);
        chk("R7 full", 32'(full_o), 1);
        chk("R7 dr", 32'(dr_o), 32'h00EE);
        cyc(1'b0, 1'b0, 1'b0, '0);
        chk("R7 pulse ends", 32'(err_o), 0);

        // drain: R3 location 0 first, R6 reverse order
        for (int i = DEPTH; i >= 1; i--) begin
            cyc(1'b0, 1'b1, 1'b0, '0);
            chk("R6 pop order", 32'(dr_o), 32'(fill_val(i)));
            if (i == DEPTH) begin
                chk("R3 location 0 first", 32'(sp_o), 63);
                chk("R4 full cleared", 32'(full_o), 0);
            end
        end
        chk("R5 empty after drain", 32'(empty_o), 1);
        chk("R5 sp after drain", 32'(sp_o), 0);

        finish_run();
    end

endmodule